// File: doc/BRIEF.md
# Fair Five-Way Bus Arbiter

This block decides which of five masters owns a single shared bus. Each master raises a request line to ask for the bus and sees a grant line in return. At most one grant is high at a time. A master keeps the bus while it goes on requesting, but only up to a tenure that grows with its position: master k may hold the bus for k cycles in a row. When the tenure runs out, the bus goes to another master that is waiting. When several masters compete at a decision point, the one whose grant is oldest wins.

Each master also has an urgent line. Raising it takes the bus at the next clock edge, even if another master holds it at that moment. Grants are registered, so they change only on a clock edge. Reset is synchronous and active high.

The usual way to use the block is to tie each master's request to its pending-transfer flag and to drive the shared bus multiplexer straight from the grant vector.

Top module: `fair_bus_arbiter`

## Requirements
- R1: The grant vector `gnt` has at most one bit set in every cycle. Bit k of `req`, `irq` and `gnt` belongs to master k+1, with bit 0 being master 1.
- R2: After a clock edge with `rst` high, `gnt` is all zero. The recency ranking is set to master 1 as the oldest, then 2, 3 and 4, with master 5 as the newest.
- R3: If any request is high at an edge, some grant is high after that edge. A lone request made while the bus is idle is granted at the next edge. With no request and no urgent line high, the bus goes idle.
- R4: A holder that still requests and is within its tenure keeps its grant. A holder whose request is low at an edge loses its grant at that edge.
- R5: Master k+1 holds the bus for at most k+1 consecutive cycles while another master is requesting. When the tenure expires and others are waiting, the bus passes to one of them at that same edge. When no other master is waiting, the expiring master is granted again with a fresh tenure.
- R6: Among the masters that compete at a decision point, the grant goes to the one granted least recently. A master becomes the newest in the ranking at the edge its grant starts. Before any grant, this ordering is the same as index order.
- R7: If the urgent line of any master other than the holder is high at an edge, that master is granted at that edge, whatever its request does. When several such lines are high, the lowest index wins.
- R8: The urgent line of the current holder has no effect. It neither extends the holder's tenure nor keeps the grant once the holder's request drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_REQ | Bus request, one bit per master |
| irq | input | N_REQ | Urgent takeover line, one bit per master |
| gnt | output | N_REQ | Registered grant, at most one bit high |

## Verification
The bound checker tests several properties on every cycle: that the grant is one-hot or zero, that the bus is never left idle while someone requests, the takeover latency with lowest-index choice among urgent lines, that a holder whose request drops is released, and a bound on each master's contested run length that it counts itself. Least-recently-used ordering cannot be seen from the ports in any single cycle, because it depends on the whole history of grants. The same holds for regranting a lone master after its tenure expires and for the ranking after reset. These behaviours are therefore shown by the bench. Its queue-based model follows random request and urgent patterns and compares the grant on every cycle, and directed sequences with fixed expected values cover the same behaviours.

// File: rtl/fair_arb_pkg.sv
package fair_arb_pkg;
  // Kind of decision taken at a clock edge
  typedef enum logic [1:0] {
    DEC_IDLE = 2'd0,
    DEC_KEEP = 2'd1,
    DEC_IRQ  = 2'd2,
    DEC_ARB  = 2'd3
  } arb_dec_e;
endpackage

// File: rtl/fair_arb_irq_sel.sv
module fair_arb_irq_sel #(
  parameter int N_REQ = 5
) (
  input  logic [N_REQ-1:0] urgent,
  output logic [N_REQ-1:0] win,
  output logic             any
);
  // Fixed priority: lowest index wins
  always_comb begin
    win = '0;
    for (int k = N_REQ - 1; k >= 0; k--) begin
      if (urgent[k]) win = N_REQ'(1) << k;
    end
  end

  assign any = |urgent;
endmodule

// File: rtl/fair_arb_lru.sv
module fair_arb_lru #(
  parameter int N_REQ = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REQ-1:0] cand,
  input  logic             upd,
  input  logic [N_REQ-1:0] upd_win,
  output logic [N_REQ-1:0] win
);
  localparam int RW = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  // Rank 0 is the oldest; ranks are always a permutation
  logic [RW-1:0] rank_q [N_REQ];
  logic [RW-1:0] win_rank;

  always_comb begin
    for (int k = 0; k < N_REQ; k++) begin
      win[k] = cand[k];
      for (int j = 0; j < N_REQ; j++) begin
        if (j != k && cand[j] && rank_q[j] < rank_q[k]) win[k] = 1'b0;
      end
    end
  end

  always_comb begin
    win_rank = '0;
    for (int k = 0; k < N_REQ; k++) begin
      if (upd_win[k]) win_rank = rank_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_REQ; k++) rank_q[k] <= RW'(k);
    end else if (upd) begin
      for (int k = 0; k < N_REQ; k++) begin
        if (upd_win[k]) rank_q[k] <= RW'(N_REQ - 1);
        else if (rank_q[k] > win_rank) rank_q[k] <= rank_q[k] - RW'(1);
      end
    end
  end
endmodule

// File: rtl/fair_arb_tenure.sv
module fair_arb_tenure #(
  parameter int N_REQ = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REQ-1:0] gnt_q,
  input  logic             start,
  input  logic             keep,
  output logic             expired
);
  localparam int CW = $clog2(N_REQ + 1);

  logic [CW-1:0]    cnt_q;
  logic [N_REQ-1:0] exp_vec;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (start) cnt_q <= CW'(1);
    else if (keep)  cnt_q <= cnt_q + CW'(1);
    else            cnt_q <= '0;
  end

  // Master k+1 has a limit of k+1 cycles
  for (genvar k = 0; k < N_REQ; k++) begin : g_lim
    assign exp_vec[k] = gnt_q[k] && (cnt_q >= CW'(k + 1));
  end

  assign expired = |exp_vec;
endmodule

// File: rtl/fair_bus_arbiter.sv
module fair_bus_arbiter
  import fair_arb_pkg::*;
#(
  parameter int N_REQ = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REQ-1:0] req,
  input  logic [N_REQ-1:0] irq,
  output logic [N_REQ-1:0] gnt
);
  logic [N_REQ-1:0] gnt_q, gnt_d;
  logic [N_REQ-1:0] irq_eff, irq_win, lru_win, cand;
  logic             irq_any, expired, keep_ok, start;
  arb_dec_e         dec;

  // The holder's own urgent line is masked out
  assign irq_eff = irq & ~gnt_q;

  fair_arb_irq_sel #(.N_REQ(N_REQ)) u_irq (
    .urgent (irq_eff),
    .win    (irq_win),
    .any    (irq_any)
  );

  fair_arb_tenure #(.N_REQ(N_REQ)) u_ten (
    .clk     (clk),
    .rst     (rst),
    .gnt_q   (gnt_q),
    .start   (start),
    .keep    (dec == DEC_KEEP),
    .expired (expired)
  );

  // Others first; an expiring holder only competes when it is alone
  always_comb begin
    cand = req & ~gnt_q;
    if (cand == '0) cand = req & gnt_q;
  end

  fair_arb_lru #(.N_REQ(N_REQ)) u_lru (
    .clk     (clk),
    .rst     (rst),
    .cand    (cand),
    .upd     (start),
    .upd_win (gnt_d),
    .win     (lru_win)
  );

  assign keep_ok = (|(req & gnt_q)) && !expired;

  always_comb begin
    dec   = DEC_IDLE;
    gnt_d = '0;
    start = 1'b0;
    if (irq_any) begin
      dec   = DEC_IRQ;
      gnt_d = irq_win;
      start = 1'b1;
    end else if (keep_ok) begin
      dec   = DEC_KEEP;
      gnt_d = gnt_q;
    end else if (|cand) begin
      dec   = DEC_ARB;
      gnt_d = lru_win;
      start = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) gnt_q <= '0;
    else     gnt_q <= gnt_d;
  end

  assign gnt = gnt_q;
endmodule

// File: rtl/fair_bus_arbiter_chk.sv
module fair_bus_arbiter_chk #(
  parameter int N_REQ = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [N_REQ-1:0] req,
  input logic [N_REQ-1:0] irq,
  input logic [N_REQ-1:0] gnt
);
  localparam int RUNW = $clog2(N_REQ + 2) + 1;

  logic [N_REQ-1:0] irq_eff, irq_low, prev_gnt;
  logic             prev_oth;
  logic [RUNW-1:0]  run_q, cur_run, lim;

  assign irq_eff = irq & ~gnt;
  assign irq_low = irq_eff & (~irq_eff + N_REQ'(1));

  always_comb begin
    lim = '0;
    for (int k = 0; k < N_REQ; k++) if (gnt[k]) lim = RUNW'(k + 1);
  end

  // Contested run: consecutive cycles of one grant with others waiting
  always_comb begin
    if (gnt == '0) cur_run = '0;
    else if (gnt == prev_gnt && prev_oth && run_q != '1) cur_run = run_q + RUNW'(1);
    else cur_run = RUNW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_gnt <= '0;
      prev_oth <= 1'b0;
      run_q    <= '0;
    end else begin
      prev_gnt <= gnt;
      prev_oth <= |(req & ~gnt);
      run_q    <= cur_run;
    end
  end

  p_onehot_r1: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));

  p_reset_idle_r2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> gnt == '0);

  p_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (|req) |=> (|gnt));

  p_release_r4: assert property (@(posedge clk) disable iff (rst)
    (irq_eff == '0 && (gnt & ~req) != '0) |=> (gnt & $past(gnt)) == '0);

  p_tenure_r5: assert property (@(posedge clk) disable iff (rst)
    cur_run <= lim);

  p_takeover_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_eff != '0) |=> gnt == $past(irq_low));

  p_holder_irq_r8: assert property (@(posedge clk) disable iff (rst)
    ((gnt & irq) != '0 && (gnt & ~req) != '0 && irq_eff == '0)
      |=> (gnt & $past(gnt)) == '0);
endmodule

bind fair_bus_arbiter fair_bus_arbiter_chk #(.N_REQ(N_REQ)) u_chk (
  .clk (clk),
  .rst (rst),
  .req (req),
  .irq (irq),
  .gnt (gnt)
);

// File: tb/fair_bus_arbiter_test.sv
module fair_bus_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 5;
  localparam int WATCHDOG_CYCLES = 100000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req = '0;
  logic [N-1:0] irq = '0;
  logic [N-1:0] gnt;

  int total = 0;
  int bad = 0;

  // Behavioural reference state
  int    order[$];   // oldest first
  int    hold;       // -1 when idle
  int    cnt;
  string tag;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fair_bus_arbiter #(.N_REQ(N)) uut (
    .clk (clk),
    .rst (rst),
    .req (req),
    .irq (irq),
    .gnt (gnt)
  );

  task automatic check(input string rq, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: gnt=%b expected %b at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    order.delete();
    for (int k = 0; k < N; k++) order.push_back(k);
    hold = -1;
    cnt  = 0;
  endtask

  task automatic model_grant(input int p);
    for (int i = 0; i < order.size(); i++) begin
      if (order[i] == p) begin
        order.delete(i);
        break;
      end
    end
    order.push_back(p);
    hold = p;
    cnt  = 1;
  endtask

  task automatic model_step(input logic [N-1:0] r, input logic [N-1:0] q);
    int pick;
    int others;
    bit exp_hold;
    pick = -1;
    for (int k = 0; k < N; k++) if (q[k] && k != hold && pick < 0) pick = k;
    if (pick >= 0) begin
      model_grant(pick);
      tag = "R7";
    end else if (hold >= 0 && r[hold] && cnt < hold + 1) begin
      cnt++;
      tag = q[hold] ? "R8" : "R4";
    end else begin
      exp_hold = (hold >= 0) && r[hold];
      others = 0;
      for (int k = 0; k < N; k++) if (r[k] && k != hold) others++;
      foreach (order[i]) begin
        if (pick < 0 && r[order[i]] && order[i] != hold) pick = order[i];
      end
      if (pick < 0 && exp_hold) pick = hold;
      if (pick >= 0) begin
        tag = exp_hold ? "R5" : (others > 1 ? "R6" : "R3");
        model_grant(pick);
      end else begin
        tag  = (hold >= 0) ? "R4" : "R3";
        hold = -1;
        cnt  = 0;
      end
    end
  endtask

  function automatic logic [N-1:0] model_gnt();
    return (hold >= 0) ? (N'(1) << hold) : '0;
  endfunction

  // Called at a falling edge; returns at the next falling edge
  task automatic cycle(input logic [N-1:0] r, input logic [N-1:0] q);
    req = r;
    irq = q;
    @(posedge clk);
    model_step(r, q);
    @(negedge clk);
    check(tag, gnt, model_gnt());
    total++;
    if ($countones(gnt) > 1) begin
      bad++;
      $display("FAIL R1: gnt=%b expected at most one bit", gnt);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req = '0;
    irq = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    check("R2", gnt, 5'b00000);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();

    // R3: idle stays idle, lone request granted
    cycle(5'b00000, 5'b00000); check("R3", gnt, 5'b00000);

    // R6 then R5: everyone requests from reset order
    cycle(5'b11111, 5'b00000); check("R6", gnt, 5'b00001);
    cycle(5'b11111, 5'b00000); check("R5", gnt, 5'b00010);
    cycle(5'b11111, 5'b00000); check("R4", gnt, 5'b00010);
    cycle(5'b11111, 5'b00000); check("R5", gnt, 5'b00100);

    // R7: takeover by master 5; R8: its own urgent line ignored
    cycle(5'b11111, 5'b10000); check("R7", gnt, 5'b10000);
    cycle(5'b11111, 5'b10000); check("R8", gnt, 5'b10000);
    cycle(5'b11111, 5'b01010); check("R7", gnt, 5'b00010);
    // R8: holder drops request with its urgent line high
    cycle(5'b00000, 5'b00010); check("R8", gnt, 5'b00000);

    // R3 lone request, R5 regrant while alone for many cycles
    cycle(5'b01000, 5'b00000); check("R3", gnt, 5'b01000);
    for (int i = 0; i < 10; i++) cycle(5'b01000, 5'b00000);
    check("R5", gnt, 5'b01000);
    cycle(5'b00000, 5'b00000); check("R4", gnt, 5'b00000);

    // R6: recency beats index after a fresh reset
    do_reset();
    cycle(5'b00001, 5'b00000); check("R3", gnt, 5'b00001);
    cycle(5'b00000, 5'b00000); check("R4", gnt, 5'b00000);
    cycle(5'b00011, 5'b00000); check("R6", gnt, 5'b00010);

    // R2: reset in the middle of a grant
    do_reset();
    cycle(5'b00100, 5'b00000); check("R3", gnt, 5'b00100);

    // Random patterns against the model
    for (int i = 0; i < 4000; i++) begin
      logic [N-1:0] r;
      logic [N-1:0] q;
      r = N'($urandom);
      q = ($urandom_range(0, 9) == 0) ? N'($urandom) : '0;
      if ($urandom_range(0, 3) == 0) r = r & N'($urandom);
      cycle(r, q);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule